// File: doc/BRIEF.md
# Crystal-Clocked Watchdog with Reset Sequencing

This block is a fixed-duration watchdog timer that runs on the 32768 Hz real-time-clock clock. Software cannot switch it off. Software keeps it quiet by writing a one to the refresh bit of a small command word. If the refresh does not arrive within the timeout window (49152 clock cycles, 1.5 s, by default), the block does three things. It pulses a chip-level reset, sets a sticky overflow flag, and holds the processor in reset for a fixed number of cycles (4100 by default, about 125 ms). After that it releases the processor with a one-cycle launch pulse, and the processor boots from address zero.

Only two hardware inputs stop the count: a board strap and a debug-enable input. The count is also held at zero while the internal wake signal is low. An optional early-warning interrupt fires a fixed lead (33 cycles, about 1 ms) before the overflow, so that software can log its state before the reset. The overflow flag is not cleared by the watchdog's own reset. Software clears it after reading it, and the external reset pin also clears it.

All ports are plain control and status signals. The block has no data stream, so it needs no valid/ready handshake. A command is accepted on every clock edge where `fw_wr` is high, and the block never back-pressures the writer.

Top module: `rtc_watchdog`

## Requirements
- R1: While `rst_pin_n` is low and after it is released, `chip_rst`, `cpu_rst`, `cpu_launch`, `ovf_flag` and `warn_irq` are all 0.
- R2: When counting is allowed and no refresh arrives, `chip_rst` is high for exactly one cycle. It rises on the TIMEOUT_CYCLES-th rising edge after the edge at which the count was last zeroed (a refresh, a hold release, or the end of reset).
- R3: A write (`fw_wr`=1) with `fw_data[0]`=1 zeroes the count. A write with `fw_data[0]`=0 leaves the count running.
- R4: `cpu_rst` rises together with `chip_rst` and stays high for exactly HOLD_CYCLES cycles. `cpu_launch` is a one-cycle pulse in the first cycle after `cpu_rst` falls.
- R5: `ovf_flag` is set on overflow and stays set through the hold and after release. A write with `fw_data[1]`=1 clears it. If an overflow and a clear fall on the same edge, the overflow wins.
- R6: A low level on `rst_pin_n` clears the timeout count, the hold sequence, `ovf_flag` and `warn_irq` at once, without waiting for a clock edge.
- R7: While `strap_dis` or `dbg_en` is high, the count is held at zero and no overflow can occur.
- R8: While `wake` is low, the count is held at zero.
- R9: When `warn_ien` is 1, `warn_irq` rises WARN_LEAD edges before `chip_rst` rises. When `warn_ien` is 0, the warning is never raised.
- R10: `warn_irq` stays high until it is cleared by a write with `fw_data[2]`=1 or by an accepted refresh. It is raised at most once per timeout period.
- R11: A refresh written while `cpu_rst` is high is ignored. After the launch, the next overflow comes TIMEOUT_CYCLES edges after the launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | 32768 Hz real-time-clock clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wake | input | 1 | Internal wake level; the count is held at zero while low |
| strap_dis | input | 1 | Hardware strap that disables the count |
| dbg_en | input | 1 | Debug enable that disables the count |
| warn_ien | input | 1 | Early-warning interrupt enable |
| fw_wr | input | 1 | Software command write strobe |
| fw_data | input | 3 | Command bits: [0] refresh, [1] clear overflow flag, [2] clear warning |
| chip_rst | output | 1 | One-cycle chip reset pulse on overflow |
| cpu_rst | output | 1 | Processor reset held during the post-overflow delay |
| cpu_launch | output | 1 | One-cycle pulse that starts the processor from address zero |
| ovf_flag | output | 1 | Sticky flag that marks a watchdog-caused reset |
| warn_irq | output | 1 | Sticky early-warning interrupt |

## Verification
The timeout count cannot be seen at the ports. A count that is off by even one edge therefore shows up only as `chip_rst` or `warn_irq` rising one cycle early or late, up to a full timeout window after the fault. A hold counter that is off by one stretches or shortens `cpu_rst` and moves `cpu_launch` within a single hold period. A flag with the wrong clear priority stays wrong until the next software write. For this reason the bench checks every output on every cycle against an independent edge-counting model, with random refresh rates and wake and disable glitches, so that a timing slip is caught on the first overflow it affects.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Command word bit positions; software decodes the same layout.
  localparam int unsigned CMD_W         = 3;
  localparam int unsigned CMD_REFRESH   = 0;
  localparam int unsigned CMD_CLR_OVF   = 1;
  localparam int unsigned CMD_CLR_WARN  = 2;

  typedef struct packed {
    logic clr_warn;
    logic clr_ovf;
    logic refresh;
  } wdg_cmd_t;

  function automatic wdg_cmd_t decode_cmd(input logic wr, input logic [CMD_W-1:0] d);
    wdg_cmd_t c;
    c.refresh  = wr & d[CMD_REFRESH];
    c.clr_ovf  = wr & d[CMD_CLR_OVF];
    c.clr_warn = wr & d[CMD_CLR_WARN];
    return c;
  endfunction
endpackage

// File: rtl/wdg_timeout_ctr.sv
module wdg_timeout_ctr #(
  parameter int unsigned TIMEOUT_CYCLES = 49152,
  parameter int unsigned WARN_LEAD      = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic kick,
  input  logic hold_active,
  output logic kick_acc,
  output logic warn_hit,
  output logic ovf_hit
);
  localparam int unsigned CW       = $clog2(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LAST   = CW'(TIMEOUT_CYCLES - 1);
  localparam logic [CW-1:0] WARN_AT = CW'(TIMEOUT_CYCLES - 1 - WARN_LEAD);

  logic [CW-1:0] cnt;
  logic          counting;

  assign kick_acc = kick & ~hold_active;
  assign counting = run_en & ~hold_active & ~kick_acc;
  assign warn_hit = counting & (cnt == WARN_AT);
  assign ovf_hit  = counting & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!counting || ovf_hit) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R7 / R8: a stopped or asleep timer does not advance
  assert_held_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '0));
  // R11: no counting progress during the processor hold
  assert_idle_in_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> (cnt == '0));
  // R3: an accepted refresh restarts from zero
  assert_refresh_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_acc |=> (cnt == '0));
endmodule

// File: rtl/wdg_hold_seq.sv
module wdg_hold_seq #(
  parameter int unsigned HOLD_CYCLES = 4100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_hit,
  output logic hold_active,
  output logic chip_rst,
  output logic cpu_launch
);
  localparam int unsigned HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_active <= 1'b0;
      hold_cnt    <= '0;
      chip_rst    <= 1'b0;
      cpu_launch  <= 1'b0;
    end else begin
      chip_rst   <= ovf_hit;
      cpu_launch <= 1'b0;
      if (hold_active) begin
        if (hold_cnt == HOLD_LAST) begin
          hold_active <= 1'b0;
          cpu_launch  <= 1'b1;
          hold_cnt    <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else if (ovf_hit) begin
        hold_active <= 1'b1;
        hold_cnt    <= '0;
      end
    end
  end

  assert_chip_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);
  assert_chip_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> hold_active);
  assert_launch_after_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> cpu_launch);
  assert_launch_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_launch |=> !cpu_launch && !hold_active);
endmodule

// File: rtl/wdg_status.sv
module wdg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_hit,
  input  logic warn_hit,
  input  logic warn_ien,
  input  logic kick_acc,
  input  logic clr_ovf,
  input  logic clr_warn,
  output logic ovf_flag,
  output logic warn_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (ovf_hit)  ovf_flag <= 1'b1;
    else if (clr_ovf)  ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   warn_irq <= 1'b0;
    else if (clr_warn || kick_acc) warn_irq <= 1'b0;
    else if (warn_hit && warn_ien) warn_irq <= 1'b1;
  end

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
  assert_ovf_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf_flag);
  assert_warn_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_warn || kick_acc) |=> !warn_irq);
  assert_warn_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!warn_irq && !warn_ien) |=> !warn_irq);
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 49152,
  parameter int unsigned WARN_LEAD      = 33,
  parameter int unsigned HOLD_CYCLES    = 4100
) (
  input  logic                      clk_rtc,
  input  logic                      rst_pin_n,
  input  logic                      wake,
  input  logic                      strap_dis,
  input  logic                      dbg_en,
  input  logic                      warn_ien,
  input  logic                      fw_wr,
  input  logic [wdg_pkg::CMD_W-1:0] fw_data,
  output logic                      chip_rst,
  output logic                      cpu_rst,
  output logic                      cpu_launch,
  output logic                      ovf_flag,
  output logic                      warn_irq
);
  import wdg_pkg::*;

  wdg_cmd_t cmd;
  logic     run_en, kick_acc, warn_hit, ovf_hit, hold_active;

  assign cmd    = decode_cmd(fw_wr, fw_data);
  assign run_en = wake & ~strap_dis & ~dbg_en;

  wdg_timeout_ctr #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .WARN_LEAD     (WARN_LEAD)
  ) u_ctr (
    .clk        (clk_rtc),
    .rst_n      (rst_pin_n),
    .run_en     (run_en),
    .kick       (cmd.refresh),
    .hold_active(hold_active),
    .kick_acc   (kick_acc),
    .warn_hit   (warn_hit),
    .ovf_hit    (ovf_hit)
  );

  wdg_hold_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk        (clk_rtc),
    .rst_n      (rst_pin_n),
    .ovf_hit    (ovf_hit),
    .hold_active(hold_active),
    .chip_rst   (chip_rst),
    .cpu_launch (cpu_launch)
  );

  wdg_status u_stat (
    .clk     (clk_rtc),
    .rst_n   (rst_pin_n),
    .ovf_hit (ovf_hit),
    .warn_hit(warn_hit),
    .warn_ien(warn_ien),
    .kick_acc(kick_acc),
    .clr_ovf (cmd.clr_ovf),
    .clr_warn(cmd.clr_warn),
    .ovf_flag(ovf_flag),
    .warn_irq(warn_irq)
  );

  assign cpu_rst = hold_active;

  // R7: disabled timer never overflows
  assert_no_ovf_disabled_R7: assert property (@(posedge clk_rtc) disable iff (!rst_pin_n)
    (strap_dis || dbg_en) |-> !ovf_hit);
endmodule

// File: tb/rtc_watchdog_test.sv
module rtc_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 120;
  localparam int W = 33;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic wake = 1'b1, strap_dis = 1'b0, dbg_en = 1'b0, warn_ien = 1'b0;
  logic fw_wr = 1'b0;
  logic [2:0] fw_data = '0;
  logic chip_rst, cpu_rst, cpu_launch, ovf_flag, warn_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_watchdog #(.TIMEOUT_CYCLES(T), .WARN_LEAD(W), .HOLD_CYCLES(H)) uut (
    .clk_rtc(clk), .rst_pin_n(rst_pin_n), .wake(wake), .strap_dis(strap_dis),
    .dbg_en(dbg_en), .warn_ien(warn_ien), .fw_wr(fw_wr), .fw_data(fw_data),
    .chip_rst(chip_rst), .cpu_rst(cpu_rst), .cpu_launch(cpu_launch),
    .ovf_flag(ovf_flag), .warn_irq(warn_irq));

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: edges remaining until overflow, from the requirements
  int m_left, m_hleft;
  bit m_hold, m_chip, m_launch, m_ovf, m_warn;
  wire m_kick = fw_wr && fw_data[0] && !m_hold;                  // R3, R11
  wire m_run  = wake && !strap_dis && !dbg_en && !m_hold && !m_kick; // R7, R8
  wire m_boom = m_run && (m_left == 1);                          // R2
  wire m_ring = m_run && (m_left - 1 == W) && warn_ien;          // R9

  function automatic int next_left(bit run, bit boom, int left);
    if (!run || boom) return T;
    return left - 1;
  endfunction

  always @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin  // R6
      m_left <= T; m_hleft <= 0; m_hold <= 0; m_chip <= 0;
      m_launch <= 0; m_ovf <= 0; m_warn <= 0;
    end else begin
      m_chip   <= m_boom;
      m_launch <= 1'b0;
      if (m_hold) begin
        if (m_hleft == 1) begin m_hold <= 1'b0; m_launch <= 1'b1; end
        m_hleft <= m_hleft - 1;
      end else if (m_boom) begin
        m_hold <= 1'b1; m_hleft <= H;
      end
      m_left <= next_left(m_run, m_boom, m_left);
      if (m_boom) m_ovf <= 1'b1;
      else if (fw_wr && fw_data[1]) m_ovf <= 1'b0;   // R5
      if ((fw_wr && fw_data[2]) || m_kick) m_warn <= 1'b0;  // R10
      else if (m_ring) m_warn <= 1'b1;
    end
  end

  always @(negedge clk) if (cmp_on && !done) begin
    chk("R2", "chip_rst", chip_rst, m_chip);
    chk("R4", "cpu_rst", cpu_rst, m_hold);
    chk("R4", "cpu_launch", cpu_launch, m_launch);
    chk("R5", "ovf_flag", ovf_flag, m_ovf);
    chk("R10", "warn_irq", warn_irq, m_warn);
  end

  task automatic step(bit wr = 0, logic [2:0] d = 3'b000);
    @(negedge clk); #1;
    fw_wr = wr; fw_data = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  int rise_chip, rise_warn, launch_at, cyc;
  always @(posedge clk) cyc <= cyc + 1;
  initial cyc = 0;
  always @(posedge chip_rst) rise_chip = cyc;
  always @(posedge warn_irq) rise_warn = cyc;
  always @(posedge cpu_launch) launch_at = cyc;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "chip_rst", chip_rst, 1'b0);
    chk("R1", "cpu_rst", cpu_rst, 1'b0);
    chk("R1", "ovf_flag", ovf_flag, 1'b0);
    chk("R1", "warn_irq", warn_irq, 1'b0);
    #1 rst_pin_n = 1'b1;
    cmp_on = 1'b1;
    chk("R1", "cpu_launch", cpu_launch, 1'b0);

    // R2, R9: full timeout with warning enabled
    warn_ien = 1'b1;
    step(1, 3'b001);
    idle(T + 5);
    chk("R9", "warn lead", (rise_chip - rise_warn) == W, 1'b1);
    chk("R5", "flag after ovf", ovf_flag, 1'b1);
    // R11: refresh during hold is ignored
    step(1, 3'b001);
    idle(H + 2);
    idle(T - 5);
    chk("R11", "no early ovf", chip_rst, 1'b0);
    idle(10);
    chk("R11", "ovf after launch", (rise_chip - launch_at) == T, 1'b1);
    idle(H + 2);
    // R5: clear flag; R10: clear warning
    step(1, 3'b110);
    step();
    chk("R5", "flag cleared", ovf_flag, 1'b0);
    chk("R10", "warn cleared", warn_irq, 1'b0);
    // R3: write with refresh bit zero does not restart
    step(1, 3'b001);
    for (int i = 0; i < T / 2; i++) step(1, 3'b000);
    idle(T);
    chk("R3", "ovf despite zero writes", ovf_flag, 1'b1);
    idle(H + 2);
    // R9: warning disabled
    warn_ien = 1'b0;
    step(1, 3'b111);
    idle(T + 3);
    chk("R9", "no warn when disabled", warn_irq, 1'b0);
    idle(H);
    // R7: strap and debug disable
    strap_dis = 1'b1; idle(2 * T);
    chk("R7", "strap stops ovf", cpu_rst, 1'b0);
    strap_dis = 1'b0; dbg_en = 1'b1; idle(2 * T);
    chk("R7", "debug stops ovf", cpu_rst, 1'b0);
    dbg_en = 1'b0;
    // R8: wake low holds count
    for (int i = 0; i < 3 * T; i++) begin step(); wake = (i % (T - 10)) != 0; end
    wake = 1'b1;
    chk("R8", "wake low restarts", cpu_rst, 1'b0);
    // R6: async reset in the middle of the hold
    warn_ien = 1'b1;
    idle(T + 5);
    #2 rst_pin_n = 1'b0;
    #1;
    chk("R6", "cpu_rst async", cpu_rst, 1'b0);
    chk("R6", "ovf async", ovf_flag, 1'b0);
    chk("R6", "warn async", warn_irq, 1'b0);
    idle(2);
    rst_pin_n = 1'b1;

    // Constrained random segments with fixed seed
    for (int s = 0; s < 40; s++) begin
      int kp = ($urandom % 3 == 0) ? 0 : (($urandom % 2) ? 1 : 6);
      warn_ien = $urandom % 4 != 0;
      for (int i = 0; i < 300; i++) begin
        bit wr = ($urandom % 100) < kp + 1;
        logic [2:0] d = 3'($urandom);
        if (kp == 0 && d[0]) wr = 1'b0;
        step(wr, d);
        wake = ($urandom % 200) != 0;
        strap_dis = ($urandom % 400) == 0;
        dbg_en = ($urandom % 400) == 0;
      end
    end
    idle(3);
    finish_run();
  end
endmodule